// File: doc/BRIEF.md
# Boundary Scan Test Port Controller

This block is the logic behind a four-wire boundary scan test port. It follows the test clock and mode select to step a sixteen-state controller. It holds a 3-bit instruction, and it links one data register between the serial test input and the serial test output. The data register is the bypass bit, the 32-bit identification word or the boundary scan chain. It also chooses how each output pin is driven. The pin can follow the core, take its value and enable from the boundary cells, or be switched off.

Test equipment loads an instruction through the instruction path. It then scans data through the data path. Under the sample and preload instruction the core keeps control of its pins. Under the external test and clamp instructions the pins show the values held in the boundary cells. Under the high-impedance instruction every output enable is forced low. The boundary chain runs from bit 0 (nearest the serial output) upward. It holds `N_IN` input cells first, then `N_OUT` output value cells, then `N_OUT` output enable cells.

Top module: `tap_scan_unit`

## Requirements
- R1: The controller follows the standard sixteen-state sequence on rising test clock edges. Five rising edges in a row with `tms` high bring it to the reset state from any state.
- R2: The reset state, and `trst` high (asynchronous, active high), force the active instruction to the identification code 3'b001.
- R3: Capture of the instruction path loads 3'b001, which is shifted out first. The active instruction changes only on leaving the update-instruction state (or in the reset state).
- R4: The instruction codes are: 3'b000 external test, 3'b001 identification, 3'b010 sample/preload, 3'b011 clamp, 3'b100 high impedance, 3'b111 bypass. Codes 3'b101 and 3'b110 act as bypass. The boundary chain is selected for 000 and 010, the 32-bit identification register for 001, and the single bypass bit (which captures 0) for all others.
- R5: The identification register loads {VERSION[3:0] in 31:28, PART_NUM[15:0] in 27:12, MFR_CODE[10:0] in 11:1, 1 in bit 0} at data capture. It shifts out least significant bit first.
- R6: The boundary chain captures {core_oe, core_out, pin_in} (pin_in in the lowest bits). `tdi` enters at the top bit and `tdo` takes bit 0. The hold latches take the chain only on update-data with the chain selected.
- R7: Under sample/preload, identification and bypass, `pin_out` equals `core_out` and `pin_oe` equals `core_oe`.
- R8: Under external test and clamp, `pin_out` equals hold latch bits [N_IN+N_OUT-1:N_IN] and `pin_oe` equals hold latch bits [N_IN+2*N_OUT-1:N_IN+N_OUT].
- R9: Under clamp, data scans pass through the bypass bit and leave the hold latches, and so the pins, unchanged.
- R10: Under high impedance, every bit of `pin_oe` is 0 and `pin_out` follows `core_out`.
- R11: `tdo` and `tdo_oe` change only on falling test clock edges. `tdo_oe` is 1 only while the controller is in a shift state.
- R12: `core_in` always equals `pin_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst | input | 1 | Asynchronous test reset, active high |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on falling edge |
| tdo_oe | output | 1 | Enable for the serial output driver |
| core_out | input | N_OUT | Output values from the core |
| core_oe | input | N_OUT | Output enables from the core |
| pin_in | input | N_IN | Values arriving at input pins |
| pin_out | output | N_OUT | Values toward output pads |
| pin_oe | output | N_OUT | Enables toward output pads |
| core_in | output | N_IN | Input pin values passed to the core |

## Verification
A capture takes effect on the rising edge that leaves the capture state. The bit at bit 0 appears on `tdo` at the next falling edge, and each later bit appears one falling edge after the rising edge that shifts it. A new instruction changes the pin mode on the rising edge that leaves update-instruction. New hold latch contents reach the pins on the rising edge that leaves update-data. The bench changes `tms` and `tdi` one nanosecond after a falling edge, lets one full cycle pass, and samples one nanosecond after the next falling edge. Every result therefore has settled when it is read. One directed case also samples `tdo` between the rising and falling edge, to show the output waits for the falling edge.

// File: rtl/tap_pkg.sv
package tap_pkg;
  localparam int IR_W  = 3;
  localparam int ID_W  = 32;

  localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b010;
  localparam logic [IR_W-1:0] OP_CLAMP  = 3'b011;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPT   = {{(IR_W-2){1'b0}}, 2'b01};

  typedef enum logic [3:0] {
    S_TLR, S_RTI,
    S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
    S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tap_st_e;

  typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_BSR} dr_sel_e;
  typedef enum logic [1:0] {MODE_CORE, MODE_CELL, MODE_OFF} pin_mode_e;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic    tck,
  input  logic    trst,
  input  logic    tms,
  output tap_st_e st
);
  tap_st_e nx;

  always_ff @(posedge tck or posedge trst) begin
    if (trst) st <= S_TLR;
    else      st <= nx;
  end

  always_comb begin
    case (st)
      S_TLR:    nx = tms ? S_TLR    : S_RTI;
      S_RTI:    nx = tms ? S_SEL_DR : S_RTI;
      S_SEL_DR: nx = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: nx = tms ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  nx = tms ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: nx = tms ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: nx = tms ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: nx = tms ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: nx = tms ? S_SEL_DR : S_RTI;
      S_SEL_IR: nx = tms ? S_TLR    : S_CAP_IR;
      S_CAP_IR: nx = tms ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  nx = tms ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: nx = tms ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: nx = tms ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: nx = tms ? S_UPD_IR : S_SH_IR;
      S_UPD_IR: nx = tms ? S_SEL_DR : S_RTI;
      default:  nx = S_TLR;
    endcase
  end

  // checker: run length of tms high, saturating at five
  logic [2:0] hi_run;
  always_ff @(posedge tck or posedge trst) begin
    if (trst)               hi_run <= '0;
    else if (!tms)          hi_run <= '0;
    else if (hi_run != 3'd5) hi_run <= hi_run + 3'd1;
  end

  assert_tms_reset_R1: assert property (@(posedge tck) disable iff (trst)
    (hi_run == 3'd5) |-> (st == S_TLR));
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic            tck,
  input  logic            trst,
  input  tap_st_e         st,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_lsb
);
  logic [IR_W-1:0] ir_sh;

  always_ff @(posedge tck or posedge trst) begin
    if (trst) begin
      ir_sh <= '0;
      ir_q  <= OP_IDCODE;
    end else begin
      if (st == S_CAP_IR)     ir_sh <= IR_CAPT;
      else if (st == S_SH_IR) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
      if (st == S_TLR)        ir_q <= OP_IDCODE;
      else if (st == S_UPD_IR) ir_q <= ir_sh;
    end
  end

  assign ir_lsb = ir_sh[0];

  assert_ir_hold_R3: assert property (@(posedge tck) disable iff (trst)
    (st != S_UPD_IR && st != S_TLR) |=> $stable(ir_q));
  assert_tlr_idcode_R2: assert property (@(posedge tck) disable iff (trst)
    (st == S_TLR) |=> (ir_q == OP_IDCODE));
endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter logic [10:0] MFR_CODE = 11'h0A1,
  parameter logic [15:0] PART_NUM = 16'h5C3E,
  parameter logic [3:0]  VERSION  = 4'h2
)(
  input  logic            tck,
  input  logic            trst,
  input  tap_st_e         st,
  input  logic [IR_W-1:0] ir_q,
  input  logic            tdi,
  input  logic            ir_lsb,
  input  logic            bsr_lsb,
  output logic            bsr_sel,
  output pin_mode_e       mode,
  output logic            tdo,
  output logic            tdo_oe
);
  localparam logic [ID_W-1:0] ID_VAL = {VERSION, PART_NUM, MFR_CODE, 1'b1};

  dr_sel_e         sel;
  logic            byp;
  logic [ID_W-1:0] id_sh;
  logic            dr_lsb;

  always_comb begin
    case (ir_q)
      OP_EXTEST, OP_SAMPLE: sel = SEL_BSR;
      OP_IDCODE:            sel = SEL_ID;
      default:              sel = SEL_BYP;
    endcase
    case (ir_q)
      OP_EXTEST, OP_CLAMP: mode = MODE_CELL;
      OP_HIGHZ:            mode = MODE_OFF;
      default:             mode = MODE_CORE;
    endcase
  end

  assign bsr_sel = (sel == SEL_BSR);

  always_ff @(posedge tck or posedge trst) begin
    if (trst) begin
      byp   <= 1'b0;
      id_sh <= '0;
    end else if (st == S_CAP_DR) begin
      if (sel == SEL_BYP) byp   <= 1'b0;
      if (sel == SEL_ID)  id_sh <= ID_VAL;
    end else if (st == S_SH_DR) begin
      if (sel == SEL_BYP) byp   <= tdi;
      if (sel == SEL_ID)  id_sh <= {tdi, id_sh[ID_W-1:1]};
    end
  end

  always_comb begin
    case (sel)
      SEL_BSR: dr_lsb = bsr_lsb;
      SEL_ID:  dr_lsb = id_sh[0];
      default: dr_lsb = byp;
    endcase
  end

  always_ff @(negedge tck or posedge trst) begin
    if (trst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= (st == S_SH_IR) ? ir_lsb : dr_lsb;
      tdo_oe <= (st == S_SH_IR) || (st == S_SH_DR);
    end
  end

  assert_id_lsb_R5: assert property (@(posedge tck) disable iff (trst)
    (st == S_CAP_DR && ir_q == OP_IDCODE) |=> (id_sh[0] == 1'b1));
  assert_tdo_oe_shift_R11: assert property (@(posedge tck) disable iff (trst)
    tdo_oe |-> (st == S_SH_IR || st == S_SH_DR));
endmodule

// File: rtl/tap_bsr.sv
module tap_bsr
  import tap_pkg::*;
#(
  parameter int N_OUT = 4,
  parameter int N_IN  = 4
)(
  input  logic             tck,
  input  logic             trst,
  input  tap_st_e          st,
  input  logic             tdi,
  input  logic             bsr_sel,
  input  pin_mode_e        mode,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OUT-1:0] core_oe,
  input  logic [N_IN-1:0]  pin_in,
  output logic             bsr_lsb,
  output logic [N_OUT-1:0] pin_out,
  output logic [N_OUT-1:0] pin_oe,
  output logic [N_IN-1:0]  core_in
);
  localparam int L      = N_IN + 2 * N_OUT;
  localparam int OUT_LO = N_IN;
  localparam int OE_LO  = N_IN + N_OUT;

  logic [L-1:0] cells, hold;

  always_ff @(posedge tck or posedge trst) begin
    if (trst) begin
      cells <= '0;
      hold  <= '0;
    end else if (bsr_sel) begin
      if (st == S_CAP_DR)     cells <= {core_oe, core_out, pin_in};
      else if (st == S_SH_DR) cells <= {tdi, cells[L-1:1]};
      if (st == S_UPD_DR)     hold <= cells;
    end
  end

  assign bsr_lsb = cells[0];
  assign core_in = pin_in;

  for (genvar g = 0; g < N_OUT; g++) begin : g_pin
    assign pin_out[g] = (mode == MODE_CELL) ? hold[OUT_LO+g] : core_out[g];
    assign pin_oe[g]  = (mode == MODE_CELL) ? hold[OE_LO+g] :
                        (mode == MODE_OFF)  ? 1'b0 : core_oe[g];
  end

  assert_clamp_hold_R9: assert property (@(posedge tck) disable iff (trst)
    (mode == MODE_CELL && !bsr_sel) |=> $stable(hold));
  assert_hold_only_update_R6: assert property (@(posedge tck) disable iff (trst)
    (st != S_UPD_DR) |=> $stable(hold));
endmodule

// File: rtl/tap_scan_unit.sv
module tap_scan_unit
  import tap_pkg::*;
#(
  parameter int          N_OUT    = 4,
  parameter int          N_IN     = 4,
  parameter logic [10:0] MFR_CODE = 11'h0A1,
  parameter logic [15:0] PART_NUM = 16'h5C3E,
  parameter logic [3:0]  VERSION  = 4'h2
)(
  input  logic             tck,
  input  logic             trst,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_oe,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OUT-1:0] core_oe,
  input  logic [N_IN-1:0]  pin_in,
  output logic [N_OUT-1:0] pin_out,
  output logic [N_OUT-1:0] pin_oe,
  output logic [N_IN-1:0]  core_in
);
  tap_st_e         st;
  logic [IR_W-1:0] ir_q;
  logic            ir_lsb, bsr_lsb, bsr_sel;
  pin_mode_e       mode;

  tap_fsm u_fsm (.tck(tck), .trst(trst), .tms(tms), .st(st));

  tap_ir u_ir (.tck(tck), .trst(trst), .st(st), .tdi(tdi),
               .ir_q(ir_q), .ir_lsb(ir_lsb));

  tap_dr #(.MFR_CODE(MFR_CODE), .PART_NUM(PART_NUM), .VERSION(VERSION)) u_dr (
    .tck(tck), .trst(trst), .st(st), .ir_q(ir_q), .tdi(tdi),
    .ir_lsb(ir_lsb), .bsr_lsb(bsr_lsb), .bsr_sel(bsr_sel), .mode(mode),
    .tdo(tdo), .tdo_oe(tdo_oe));

  tap_bsr #(.N_OUT(N_OUT), .N_IN(N_IN)) u_bsr (
    .tck(tck), .trst(trst), .st(st), .tdi(tdi), .bsr_sel(bsr_sel),
    .mode(mode), .core_out(core_out), .core_oe(core_oe), .pin_in(pin_in),
    .bsr_lsb(bsr_lsb), .pin_out(pin_out), .pin_oe(pin_oe), .core_in(core_in));

  assert_highz_off_R10: assert property (@(posedge tck) disable iff (trst)
    (ir_q == OP_HIGHZ) |-> (pin_oe == '0));
  assert_core_mode_R7: assert property (@(posedge tck) disable iff (trst)
    (ir_q == OP_SAMPLE || ir_q == OP_BYPASS) |-> (pin_oe == core_oe && pin_out == core_out));
endmodule

// File: tb/tb_tap_scan_unit.sv
module tb_tap_scan_unit;
  localparam int N_OUT = 4;
  localparam int N_IN  = 4;
  localparam int L     = N_IN + 2 * N_OUT;
  localparam logic [10:0] MFR = 11'h0A1;
  localparam logic [15:0] PRT = 16'h5C3E;
  localparam logic [3:0]  VER = 4'h2;
  localparam logic [31:0] ID  = {VER, PRT, MFR, 1'b1};

  typedef struct packed {
    logic [2:0]  op;
    logic [47:0] pat;
    logic [3:0]  co, oe, pi;
  } vec_t;

  localparam vec_t TAB [10] = '{
    '{3'b010, 48'hA5C3_9E17_B24D, 4'h5, 4'hF, 4'h9},
    '{3'b000, 48'h3C96_0F1E_D2B8, 4'hA, 4'h3, 4'h6},
    '{3'b011, 48'hFFFF_0000_1234, 4'h1, 4'h0, 4'hC},
    '{3'b100, 48'h0123_4567_89AB, 4'h7, 4'hE, 4'h2},
    '{3'b001, 48'hDEAD_BEEF_CAFE, 4'h3, 4'h5, 4'hA},
    '{3'b111, 48'h8000_0000_0001, 4'hC, 4'h9, 4'h1},
    '{3'b101, 48'h5555_AAAA_5555, 4'h6, 4'hB, 4'h4},
    '{3'b110, 48'h1357_9BDF_2468, 4'h2, 4'h7, 4'hF},
    '{3'b010, 48'h0F0F_F0F0_3C3C, 4'hE, 4'h1, 4'h8},
    '{3'b000, 48'hC3C3_5A5A_9696, 4'h9, 4'hD, 4'h3}
  };

  logic tck = 1'b0, trst = 1'b1, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_oe;
  logic [N_OUT-1:0] core_out = '0, core_oe = '0, pin_out, pin_oe;
  logic [N_IN-1:0]  pin_in = '0, core_in;
  int checks = 0, errors = 0;
  logic [L-1:0] hold_m = '0;

  always #2 tck = ~tck;

  tap_scan_unit #(.N_OUT(N_OUT), .N_IN(N_IN), .MFR_CODE(MFR),
                  .PART_NUM(PRT), .VERSION(VER)) dut (
    .tck(tck), .trst(trst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .core_out(core_out), .core_oe(core_oe), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .core_in(core_in));

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic tick(logic m, logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic load_ir(logic [2:0] op, output logic [2:0] cap);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo;
      if (i == 0) chk("R11 tdo_oe in shift-ir", 64'(tdo_oe), 64'd1);
      tick(i == 2, op[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic scan_dr(int n, logic [63:0] din, output logic [63:0] got);
    got = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin
      got[i] = tdo;
      tick(i == n - 1, din[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic pins_chk(string rq, logic [2:0] op);
    logic [3:0] eo, ee;
    case (op)
      3'b000, 3'b011: begin eo = hold_m[7:4]; ee = hold_m[11:8]; end
      3'b100:         begin eo = core_out;    ee = '0;           end
      default:        begin eo = core_out;    ee = core_oe;      end
    endcase
    chk({rq, " pin_out"}, 64'(pin_out), 64'(eo));
    chk({rq, " pin_oe"},  64'(pin_oe),  64'(ee));
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0]  cap;
    logic [63:0] got, exp, cv;
    int          len;
    core_out = 4'h5; core_oe = 4'hA; pin_in = 4'h3;
    repeat (3) @(negedge tck);
    #1 trst = 1'b0;
    // reset state
    chk("R11 tdo_oe after reset", 64'(tdo_oe), 64'd0);
    chk("R7 reset pin_out", 64'(pin_out), 64'(core_out));
    chk("R7 reset pin_oe", 64'(pin_oe), 64'(core_oe));
    chk("R12 core_in", 64'(core_in), 64'(pin_in));
    tick(0, 0);
    // R2 R5: identification selected without loading an instruction
    scan_dr(40, 64'hA5, got);
    chk("R2 R5 id after reset", got & 64'hFF_FFFF_FFFF, {24'h0, 8'hA5, ID});
    chk("R5 id bit0", 64'(got[0]), 64'd1);

    // table walk: one instruction and one 48-bit scan per row
    foreach (TAB[k]) begin
      core_out = TAB[k].co; core_oe = TAB[k].oe; pin_in = TAB[k].pi;
      load_ir(TAB[k].op, cap);
      chk("R3 ir capture", 64'(cap), 64'(3'b001));
      case (TAB[k].op)
        3'b000, 3'b010: begin len = L;  cv = 64'({core_oe, core_out, pin_in}); end
        3'b001:         begin len = 32; cv = 64'(ID); end
        default:        begin len = 1;  cv = 64'd0; end
      endcase
      scan_dr(48, 64'(TAB[k].pat), got);
      exp = (cv | (64'(TAB[k].pat) << len)) & 64'hFFFF_FFFF_FFFF;
      chk("R4 R6 scan length and capture", got, exp);
      if (len == L) hold_m = TAB[k].pat[47:48-L];
      pins_chk("R8 R9 R10 R7 pins", TAB[k].op);
      chk("R12 core_in", 64'(core_in), 64'(pin_in));
      chk("R11 tdo_oe idle", 64'(tdo_oe), 64'd0);
    end

    // R3: mode holds during instruction shift until update
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    tick(0, 0); tick(0, 0); tick(1, 1);
    chk("R3 pins before update-ir", 64'(pin_oe), 64'(hold_m[11:8]));
    tick(1, 0);
    chk("R3 pins in update-ir", 64'(pin_oe), 64'(hold_m[11:8]));
    tick(0, 0);
    chk("R10 highz after update", 64'(pin_oe), 64'd0);
    chk("R10 highz pin_out", 64'(pin_out), 64'(core_out));

    // R11: tdo moves on the falling edge only
    load_ir(3'b111, cap);
    tick(1, 0); tick(0, 0); tick(0, 0);
    chk("R11 bypass captured 0", 64'(tdo), 64'd0);
    tms = 0; tdi = 1;
    @(posedge tck); #1;
    chk("R11 tdo before fall", 64'(tdo), 64'd0);
    @(negedge tck); #1;
    chk("R11 tdo after fall", 64'(tdo), 64'd1);
    // R1: five tms highs from shift-dr reach reset
    for (int i = 0; i < 5; i++) tick(1, 0);
    chk("R1 tdo_oe off in reset", 64'(tdo_oe), 64'd0);
    chk("R1 R7 core mode", 64'(pin_oe), 64'(core_oe));
    tick(0, 0);
    scan_dr(32, 64'd0, got);
    chk("R1 R2 id after tms reset", got, 64'(ID));

    // R2: asynchronous reset mid-cycle under external test
    load_ir(3'b000, cap);
    chk("R8 extest pins", 64'(pin_out), 64'(hold_m[7:4]));
    @(posedge tck); #1 trst = 1'b1; #0.5;
    chk("R2 async reset pin_out", 64'(pin_out), 64'(core_out));
    chk("R2 async reset pin_oe", 64'(pin_oe), 64'(core_oe));
    @(negedge tck); #1 trst = 1'b0;
    tick(0, 0);
    scan_dr(32, 64'd0, got);
    chk("R2 id after async reset", got, 64'(ID));

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule